// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block holds the interrupt mask and the latched interrupt status for a serial peripheral with ten event sources. Software never writes the mask as a whole: one register address sets mask bits (a one sets the bit), another clears them (a one clears the bit). Both of these addresses read back as zero. A third address returns the current mask. A fourth returns the status, and writing ones at that address clears status bits.

Each cycle, the block samples a vector of single-cycle event pulses, one per source. A pulse whose mask bit is set is held in the status register until software clears it. The single interrupt output is registered. It is high in every cycle in which any status bit is set.

The sources sit at fixed bit positions. Bit 0 is receive trigger level reached, bit 1 is receive FIFO empty, bit 2 is receive FIFO full, bit 3 is transmit FIFO empty and bit 4 is transmit FIFO full. Bits 5 to 9 are overrun, framing error, parity error, receive timeout and modem status change. The same positions apply at all four addresses.

Top module: `ism_ctrl`

## Requirements
- R1: After reset the mask and status both read 0 and `irq` is low.
- R2: A write at address 0 sets every mask bit whose data bit is one from the next clock edge; mask bits whose data bit is zero keep their value.
- R3: A write at address 1 clears every mask bit whose data bit is one from the next clock edge; mask bits whose data bit is zero keep their value.
- R4: Reads at address 0 and address 1 always return 0.
- R5: Only data bits 9..0 take part in a write; bits 31..10 have no effect, and reads at every address return 0 in bits 31..10.
- R6: A status bit is set at a clock edge only when its event input is high at that edge and its mask bit, as it stood before that edge, is set; an event arriving in the same cycle as the write that enables its bit is not latched.
- R7: A set status bit stays set until it is cleared at address 3; clearing its mask bit does not clear it.
- R8: A write at address 3 clears every status bit whose data bit is one from the next clock edge; the other status bits are unaffected.
- R9: When an event for an enabled bit and a clear of the same status bit fall in one cycle, the status bit ends up set.
- R10: `irq` changes at the same clock edge as the status register and is high exactly when at least one status bit is set.
- R11: A write at address 2 changes neither the mask nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register select: 0 set-mask, 1 clear-mask, 2 mask, 3 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for the selected register |
| evt | input | 10 | Per-source event pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
Mask writes, status latching, status clears and `irq` all take effect at the first rising edge after the stimulus is presented. A value written or pulsed in one cycle is therefore visible one edge later, and no earlier. Read data is combinational and follows `addr` within the same cycle. The bench drives every input on the falling edge, so each stimulus spans exactly one rising edge, and it samples results just after the next falling edge. That puts each check at the first point where the new value is due. The same-cycle cases are checked in that single cycle: set against clear, and enable write against event.

// File: rtl/ism_pkg.sv
package ism_pkg;

    // Register select codes on the addr port
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_MASK_SET = 2'd0,
        SEL_MASK_CLR = 2'd1,
        SEL_MASK_RD  = 2'd2,
        SEL_STATUS   = 2'd3
    } reg_sel_e;

    // Source bit positions, shared by all four registers
    localparam int SRC_RX_TRIG   = 0;
    localparam int SRC_RX_EMPTY  = 1;
    localparam int SRC_RX_FULL   = 2;
    localparam int SRC_TX_EMPTY  = 3;
    localparam int SRC_TX_FULL   = 4;
    localparam int SRC_OVERRUN   = 5;
    localparam int SRC_FRAMING   = 6;
    localparam int SRC_PARITY    = 7;
    localparam int SRC_RX_TMO    = 8;
    localparam int SRC_MODEM_CHG = 9;
    localparam int NUM_SOURCES   = 10;

endpackage

// File: rtl/ism_mask_reg.sv
module ism_mask_reg #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [N-1:0] bits,
    output logic [N-1:0] mask_o
);

    typedef struct packed {
        logic [N-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_stb) begin
            st_d.mask = st_q.mask | bits;
        end else if (clr_stb) begin
            st_d.mask = st_q.mask & ~bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;

endmodule

// File: rtl/ism_status_reg.sv
module ism_status_reg #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] mask,
    input  logic         clr_stb,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] status_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] stat;
        logic         irq;
    } stat_state_t;

    stat_state_t  st_d, st_q;
    logic [N-1:0] hit;
    logic [N-1:0] kill;

    // Per-source qualification and clear decode
    for (genvar i = 0; i < N; i++) begin : g_src
        assign hit[i]  = evt[i] & mask[i];
        assign kill[i] = clr_stb & clr_bits[i];
    end

    always_comb begin
        st_d      = st_q;
        // Clear first, then OR in new hits so a same-cycle event wins
        st_d.stat = (st_q.stat & ~kill) | hit;
        st_d.irq  = |st_d.stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.stat;
    assign irq_o    = st_q.irq;

endmodule

// File: rtl/ism_read_mux.sv
module ism_read_mux
    import ism_pkg::*;
#(
    parameter int N  = 10,
    parameter int DW = 32
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [N-1:0]     mask,
    input  logic [N-1:0]     status,
    output logic [DW-1:0]    rdata
);

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(sel))
            SEL_MASK_RD: rdata[N-1:0] = mask;
            SEL_STATUS:  rdata[N-1:0] = status;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/ism_ctrl.sv
module ism_ctrl
    import ism_pkg::*;
#(
    parameter int N_SRC  = NUM_SOURCES,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_SRC-1:0]  evt,
    output logic              irq
);

    localparam int HI_W = DATA_W - N_SRC;

    logic [N_SRC-1:0] wr_bits;
    logic             set_stb;
    logic             clr_stb;
    logic             stat_clr_stb;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] status_q;

    assign wr_bits      = wdata[N_SRC-1:0];
    assign set_stb      = wr_en && (reg_sel_e'(addr) == SEL_MASK_SET);
    assign clr_stb      = wr_en && (reg_sel_e'(addr) == SEL_MASK_CLR);
    assign stat_clr_stb = wr_en && (reg_sel_e'(addr) == SEL_STATUS);

    // Upper write bits carry no meaning
    if (HI_W > 0) begin : g_hi
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^wdata[DATA_W-1:N_SRC];
    end

    ism_mask_reg #(.N(N_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .bits    (wr_bits),
        .mask_o  (mask_q)
    );

    ism_status_reg #(.N(N_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .mask     (mask_q),
        .clr_stb  (stat_clr_stb),
        .clr_bits (wr_bits),
        .status_o (status_q),
        .irq_o    (irq)
    );

    ism_read_mux #(.N(N_SRC), .DW(DATA_W)) u_rd (
        .sel    (addr),
        .mask   (mask_q),
        .status (status_q),
        .rdata  (rdata)
    );

endmodule

// File: rtl/ism_ctrl_chk.sv
module ism_ctrl_chk #(
    parameter int N  = 10,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic [N-1:0]  evt,
    input logic          irq,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  status_q
);

    // R2: ones set mask bits, zeros leave them alone
    a_r2_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=>
            ((mask_q & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));

    a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=>
            ((mask_q & ~$past(wdata[N-1:0])) == ($past(mask_q) & ~$past(wdata[N-1:0]))));

    // R3: ones clear mask bits, zeros leave them alone
    a_r3_clr_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> ((mask_q & $past(wdata[N-1:0])) == '0));

    a_r3_clr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=>
            ((mask_q & ~$past(wdata[N-1:0])) == ($past(mask_q) & ~$past(wdata[N-1:0]))));

    // R11: mask moves only through the set and clear addresses
    a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == 2'd0 || addr == 2'd1)) |=> $stable(mask_q));

    // R4: write-only addresses read zero
    a_r4_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd0 || addr == 2'd1) |-> (rdata == '0));

    // R5: upper read bits are zero
    a_r5_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:N] == '0);

    // R6: a status bit rises only on an enabled event
    a_r6_no_unmasked_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~($past(evt) & $past(mask_q))) == '0));

    // R9: an enabled event always lands, even against a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(evt & mask_q)) == $past(evt & mask_q)));

    // R7: status bits fall only through a status clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd3) |=> ((~status_q & $past(status_q)) == '0));

    // R10: irq tracks any set status bit
    a_r10_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status_q != '0));

endmodule

bind ism_ctrl ism_ctrl_chk #(.N(N_SRC), .DW(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .evt      (evt),
    .irq      (irq),
    .mask_q   (mask_q),
    .status_q (status_q)
);

// File: tb/ism_ctrl_bench.sv
module ism_ctrl_bench;

    localparam int N  = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd2;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [N-1:0]  evt = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] exp_mask = '0;
    logic [N-1:0] exp_stat = '0;

    always #10 clk = ~clk;

    ism_ctrl u_ism_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .evt   (evt),
        .irq   (irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus spanning exactly one rising edge
    task automatic cycle(input logic we, input logic [1:0] a, input logic [DW-1:0] d,
                         input logic [N-1:0] e);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; evt = e;
        @(negedge clk);
        wr_en = 1'b0; evt = '0; addr = 2'd2; wdata = '0;
        #1;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [DW-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic check_state(input string req);
        logic [DW-1:0] v;
        read_reg(2'd2, v);
        check({req, " mask"}, v, {{(DW-N){1'b0}}, exp_mask});
        read_reg(2'd3, v);
        check({req, " status"}, v, {{(DW-N){1'b0}}, exp_stat});
        check({req, " irq"}, {31'd0, irq}, {31'd0, (exp_stat != '0)});
    endtask

    task automatic t_reset;
        check_state("R1");
    endtask

    task automatic t_enable;
        logic [DW-1:0] v;
        cycle(1'b1, 2'd0, 32'h0000_00A5, '0);
        exp_mask = 10'h0A5;
        check_state("R2");
        cycle(1'b1, 2'd0, 32'h0000_0300, '0);
        exp_mask = 10'h3A5;
        check_state("R2 zeros keep");
        read_reg(2'd0, v);
        check("R4 addr0", v, '0);
        read_reg(2'd1, v);
        check("R4 addr1", v, '0);
        cycle(1'b1, 2'd0, 32'hFFFF_FC00, '0);
        check_state("R5 upper bits");
    endtask

    task automatic t_disable;
        cycle(1'b1, 2'd1, 32'h0000_0005, '0);
        exp_mask = 10'h3A0;
        check_state("R3");
        cycle(1'b1, 2'd2, 32'h0000_03FF, '0);
        check_state("R11");
    endtask

    task automatic t_events;
        cycle(1'b0, 2'd2, '0, 10'h3FF);
        exp_stat = 10'h3A0;
        check_state("R6 R10 latch");
        cycle(1'b0, 2'd2, '0, 10'h05F);
        check_state("R6 masked");
        cycle(1'b1, 2'd1, 32'h0000_03FF, '0);
        exp_mask = '0;
        check_state("R7 sticky");
    endtask

    task automatic t_clear;
        cycle(1'b1, 2'd3, 32'h0000_0020, '0);
        exp_stat = 10'h380;
        check_state("R8 partial");
        cycle(1'b1, 2'd3, 32'h0000_0380, '0);
        exp_stat = '0;
        check_state("R8 R10 all");
    endtask

    task automatic t_set_wins;
        cycle(1'b1, 2'd0, 32'h0000_0001, '0);
        exp_mask = 10'h001;
        cycle(1'b0, 2'd2, '0, 10'h001);
        exp_stat = 10'h001;
        cycle(1'b1, 2'd3, 32'h0000_0001, 10'h001);
        check_state("R9");
        cycle(1'b1, 2'd3, 32'h0000_0001, '0);
        exp_stat = '0;
        check_state("R9 cleanup");
    endtask

    task automatic t_enable_race;
        cycle(1'b1, 2'd0, 32'h0000_0010, 10'h010);
        exp_mask = 10'h011;
        check_state("R6 same-cycle enable");
        cycle(1'b0, 2'd2, '0, 10'h010);
        exp_stat = 10'h010;
        check_state("R6 after enable");
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_enable();
        t_disable();
        t_events();
        t_clear();
        t_set_wins();
        t_enable_race();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule